// File: doc/BRIEF.md
# Reset-Bit PWM Timer

A single-channel pulse-width modulator driven by one free-running 8-bit counter that advances on a slow timebase strobe. The strobe nominally comes at 32 kHz. A 2-bit prescaler picks which counter bit ends a period. Reaching a higher bit gives a long period, and reaching a lower bit gives a short one. The four settings give periods of 128, 64, 32 or 16 ticks, which is 250 Hz, 500 Hz, 1 kHz or 2 kHz at 32 kHz. A 7-bit high-time value, counted in ticks, sets how long the output stays high in each period.

Software reaches the timer through two byte registers, both readable and writable. The design keeps the simple behaviour of a minimal timer on purpose:
- Changing the prescaler leaves the counter running from its current value.
- A new high time acts on the next compare, not at a period boundary.
- A high time at or beyond the period holds the output high.

Any model of the block has to reproduce the glitches that follow from these rules.

Top module: `rbpwm_timer`

## Requirements
- R1: After reset both registers read 0x00, the counter is zero and the output is low.
- R2: Register offset 0 (addr = 0) is control. Bit 7 is the run enable and bits 1:0 are the prescaler p. Bits 6:2 ignore writes and read as zero.
- R3: Register offset 1 (addr = 1) holds the 7-bit high time in bits 6:0. Bit 7 ignores writes and reads as zero.
- R4: While enabled, the counter advances by one on each clock where tick is high, and holds its value on every other clock.
- R5: With prescaler p, a tick that would set counter bit (7 − p) returns the counter to zero instead. This gives periods of 128, 64, 32 and 16 ticks for p = 0..3.
- R6: While enabled, the output is high exactly when the counter bits below bit (7 − p) form a value less than the high time, and low otherwise. A high time of zero keeps the output low.
- R7: While the enable bit is 0 the output is low, and the counter is zero from the clock after the enable bit reads 0.
- R8: A prescaler write does not clear the counter. The counter keeps counting from its current value until its next tick sets the newly selected bit.
- R9: A high-time write changes the output from the first clock after the write, in mid-period.
- R10: A high time equal to or above the period holds the output high for p ≥ 1. With p = 0, the largest value (127) still gives one low tick in every 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one clock wide per counter step |
| addr | input | 1 | Register select: 0 control, 1 high time |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| pwm_o | output | 1 | PWM output |

## Verification
The counter is never visible at the ports. A wrong count, a missed wrap or a counter that is cleared on a prescaler change therefore shows up only in the position of the output edges. The error appears at the first compare whose outcome differs, which is within one period of the fault at most. A register fault shows up at once on a read-back, and within one tick at the output whenever it moves the compare. The reference model steps its own counter with every clock and checks the output on each clock. This places every edge error in the exact clock where it occurs, including edges shifted by mid-period prescaler or high-time writes.

// File: rtl/rbpwm_pkg.sv
package rbpwm_pkg;

   typedef enum logic [0:0] {
      SEL_CTRL  = 1'b0,
      SEL_HTIME = 1'b1
   } reg_sel_e;

   // Period in ticks for a counter of cnt_w bits and prescaler p.
   function automatic int period_ticks(input int cnt_w, input int p);
      return 1 << (cnt_w - 1 - p);
   endfunction

endpackage

// File: rtl/rbpwm_regs.sv
module rbpwm_regs
   import rbpwm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PSC_W  = 2,
   parameter int HT_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              run_o,
   output logic [PSC_W-1:0]  psc_o,
   output logic [HT_W-1:0]   htime_o
);

   localparam int RUN_BIT = DATA_W - 1;

   if (PSC_W >= RUN_BIT) begin : g_bad_psc
      $error("prescaler field overlaps the run bit");
   end
   if (HT_W > DATA_W) begin : g_bad_ht
      $error("high-time field wider than a register");
   end

   reg_sel_e          sel;
   logic              run_q;
   logic [PSC_W-1:0]  psc_q;
   logic [HT_W-1:0]   ht_q;
   logic [DATA_W-1:0] ctrl_view;
   logic [DATA_W-1:0] ht_view;

   assign sel = reg_sel_e'(addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         psc_q <= '0;
         ht_q  <= '0;
      end else if (wr_en) begin
         if (sel == SEL_CTRL) begin
            run_q <= wr_data[RUN_BIT];
            psc_q <= wr_data[PSC_W-1:0];
         end else begin
            ht_q <= wr_data[HT_W-1:0];
         end
      end
   end

   always_comb begin
      ctrl_view              = '0;
      ctrl_view[RUN_BIT]     = run_q;
      ctrl_view[PSC_W-1:0]   = psc_q;
      ht_view                = '0;
      ht_view[HT_W-1:0]      = ht_q;
   end

   assign rd_data = (sel == SEL_CTRL) ? ctrl_view : ht_view;
   assign run_o   = run_q;
   assign psc_o   = psc_q;
   assign htime_o = ht_q;

   // R3: a high-time write is what the register holds afterwards
   a_r3_htime_write : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 1'b1) |=> (htime_o == $past(wr_data[HT_W-1:0])));

   // R2: a control write lands in the run and prescaler fields
   a_r2_ctrl_write : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 1'b0) |=> (run_o == $past(wr_data[RUN_BIT]) &&
                                   psc_o == $past(wr_data[PSC_W-1:0])));

endmodule

// File: rtl/rbpwm_counter.sv
module rbpwm_counter #(
   parameter int CNT_W = 8,
   parameter int PSC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic [PSC_W-1:0] psc,
   output logic [CNT_W-1:0] low_o
);

   localparam int NPSC = 1 << PSC_W;

   if (NPSC > CNT_W - 1) begin : g_bad_cnt
      $error("too many prescaler settings for the counter width");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [NPSC-1:0]  hit_vec;
   logic [CNT_W-1:0] mask_vec [NPSC];

   assign cnt_inc = cnt_q + 1'b1;

   // One reset bit and one field mask per prescaler setting.
   for (genvar g = 0; g < NPSC; g++) begin : g_sel
      assign hit_vec[g]  = cnt_inc[CNT_W-1-g];
      assign mask_vec[g] = {CNT_W{1'b1}} >> (g + 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= hit_vec[psc] ? '0 : cnt_inc;
      end
   end

   assign low_o = cnt_q & mask_vec[psc];

   // R7: a stopped timer has a cleared counter one clock later
   a_r7_stop_clears : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

   // R4: no strobe, no movement
   a_r4_hold_without_tick : assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/rbpwm_compare.sv
module rbpwm_compare #(
   parameter int CNT_W   = 8,
   parameter int HT_W    = 7,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] low,
   input  logic [HT_W-1:0]  htime,
   output logic             pwm_o
);

   if (HT_W >= CNT_W) begin : g_bad_w
      $error("high-time width must be below the counter width");
   end

   logic [CNT_W-1:0] ht_ext;
   logic             level;

   assign ht_ext = CNT_W'(htime);
   assign level  = run && (low < ht_ext);

   if (OUT_REG) begin : g_flop
      logic pwm_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pwm_q <= 1'b0;
         else        pwm_q <= level;
      end
      assign pwm_o = pwm_q;

      // R7: stopped timer drives low, one clock later in this variant
      a_r7_off_low : assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> !pwm_o);
   end else begin : g_comb
      assign pwm_o = level;

      // R7: stopped timer drives low
      a_r7_off_low : assert property (@(posedge clk) disable iff (!rst_n)
         !run |-> !pwm_o);
   end

endmodule

// File: rtl/rbpwm_timer.sv
module rbpwm_timer
   import rbpwm_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int PSC_W   = 2,
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              pwm_o
);

   localparam int HT_W = CNT_W - 1;

   if (CNT_W > DATA_W) begin : g_bad_data
      $error("counter wider than a register");
   end

   logic             run;
   logic [PSC_W-1:0] psc;
   logic [HT_W-1:0]  htime;
   logic [CNT_W-1:0] low;
   logic [CNT_W-1:0] period;

   rbpwm_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .HT_W(HT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .run_o   (run),
      .psc_o   (psc),
      .htime_o (htime)
   );

   rbpwm_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .run   (run),
      .psc   (psc),
      .low_o (low)
   );

   rbpwm_compare #(.CNT_W(CNT_W), .HT_W(HT_W), .OUT_REG(OUT_REG)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .low   (low),
      .htime (htime),
      .pwm_o (pwm_o)
   );

   assign period = CNT_W'(period_ticks(CNT_W, int'(psc)));

   if (!OUT_REG) begin : g_chk_full
      // R10: high time at or above the period pins the output high
      a_r10_full_high : assert property (@(posedge clk) disable iff (!rst_n)
         (run && CNT_W'(htime) >= period) |-> pwm_o);

      // R6: a zero high time never drives the output
      a_r6_zero_low : assert property (@(posedge clk) disable iff (!rst_n)
         (htime == '0) |-> !pwm_o);
   end

endmodule

// File: tb/rbpwm_timer_test.sv
module rbpwm_timer_test;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       addr = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       pwm_o;

   int    n_cmp = 0;
   int    n_bad = 0;
   string phase = "R1";
   bit    cmp_on = 1'b0;
   bit    tick_on = 1'b0;
   int    tk = 0;
   bit    done = 1'b0;

   // behavioural reference state
   int m_cnt = 0, m_en = 0, m_psc = 0, m_cyc = 0;

   rbpwm_timer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pwm_o(pwm_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      tk   = (tk + 1) % TICK_DIV;
      tick = tick_on && (tk == 0);
   end

   always @(posedge clk) begin
      int nxt;
      if (!rst_n) begin
         m_cnt = 0; m_en = 0; m_psc = 0; m_cyc = 0;
      end else begin
         nxt = m_cnt;
         if (m_en == 0) nxt = 0;
         else if (tick) begin
            nxt = m_cnt + 1;
            if (((nxt >> (7 - m_psc)) & 1) == 1) nxt = 0;
         end
         if (wr_en) begin
            if (addr == 1'b0) begin
               m_en  = wr_data[7];
               m_psc = int'(wr_data[1:0]);
            end else begin
               m_cyc = int'(wr_data[6:0]);
            end
         end
         m_cnt = nxt;
      end
   end

   function automatic bit exp_pwm();
      return (m_en != 0) && ((m_cnt % (1 << (7 - m_psc))) < m_cyc);
   endfunction

   always @(negedge clk) begin
      if (rst_n && cmp_on && !done) begin
         n_cmp++;
         if (pwm_o !== exp_pwm()) begin
            n_bad++;
            $display("FAIL %s pwm_o actual=%b expected=%b (t=%0t)",
                     phase, pwm_o, exp_pwm(), $time);
         end
      end
   end

   task automatic wr(input bit a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input bit a, input logic [7:0] expv, input string req);
      @(negedge clk);
      addr = a;
      #1;
      n_cmp++;
      if (rd_data !== expv) begin
         n_bad++;
         $display("FAIL %s rd_data[%0d] actual=%h expected=%h", req, a, rd_data, expv);
      end
   endtask

   task automatic pwm_chk(input bit expv, input string req);
      @(negedge clk);
      #1;
      n_cmp++;
      if (pwm_o !== expv) begin
         n_bad++;
         $display("FAIL %s pwm_o actual=%b expected=%b", req, pwm_o, expv);
      end
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1 reset state
      phase = "R1";
      rd_chk(1'b0, 8'h00, "R1");
      rd_chk(1'b1, 8'h00, "R1");
      pwm_chk(1'b0, "R1");
      tick_on = 1'b1;

      // R2 / R3 register fields and read-as-zero bits
      phase = "R2";
      wr(1'b0, 8'hFF);
      rd_chk(1'b0, 8'h83, "R2");
      phase = "R3";
      wr(1'b1, 8'hFF);
      rd_chk(1'b1, 8'h7F, "R3");

      // R10 high time above a 16-tick period: constant high
      phase = "R10";
      run(200);
      pwm_chk(1'b1, "R10");

      // R7 disable
      phase = "R7";
      wr(1'b0, 8'h00);
      pwm_chk(1'b0, "R7");
      run(60);
      rd_chk(1'b0, 8'h00, "R7");

      // R5 / R6 each prescaler with an inner high time
      phase = "R5";
      wr(1'b1, 8'd40);
      wr(1'b0, 8'h80);
      run(128 * TICK_DIV * 2);
      phase = "R6";
      wr(1'b1, 8'd20);
      wr(1'b0, 8'h81);
      run(64 * TICK_DIV * 3);
      wr(1'b1, 8'd5);
      wr(1'b0, 8'h82);
      run(32 * TICK_DIV * 3);
      wr(1'b1, 8'd9);
      wr(1'b0, 8'h83);
      run(16 * TICK_DIV * 4);
      wr(1'b1, 8'd0);
      run(16 * TICK_DIV * 2);
      pwm_chk(1'b0, "R6");

      // R4 no strobes: output frozen
      phase = "R4";
      wr(1'b1, 8'd7);
      run(20);
      tick_on = 1'b0;
      run(100);
      tick_on = 1'b1;
      run(100);

      // R8 prescaler changes mid-period, counter not cleared
      phase = "R8";
      wr(1'b1, 8'd64);
      wr(1'b0, 8'h80);
      run(100 * TICK_DIV);
      wr(1'b0, 8'h83);
      run(128 * TICK_DIV);
      wr(1'b0, 8'h80);
      run(50 * TICK_DIV);
      wr(1'b0, 8'h82);
      run(128 * TICK_DIV);

      // R9 high-time change mid-period
      phase = "R9";
      wr(1'b0, 8'h80);
      run(30 * TICK_DIV);
      wr(1'b1, 8'd10);
      run(10 * TICK_DIV);
      wr(1'b1, 8'd100);
      run(128 * TICK_DIV * 2);

      // R10 full-scale limits
      phase = "R10";
      wr(1'b1, 8'd127);
      run(128 * TICK_DIV * 3);
      wr(1'b1, 8'd64);
      wr(1'b0, 8'h81);
      run(64 * TICK_DIV * 2);
      pwm_chk(1'b1, "R10");

      // R7 restart after stop begins from zero
      phase = "R7";
      wr(1'b0, 8'h00);
      run(5);
      wr(1'b1, 8'd3);
      wr(1'b0, 8'h83);
      run(16 * TICK_DIV * 3);

      summary();
   end

endmodule